// File: doc/BRIEF.md
# Multi-channel DMA transfer engine

This block is a memory-to-memory transfer engine with 32 channels. Each channel holds its own descriptor: a source address, a destination address, a count of values and a control word. A channel becomes pending in three ways. A peripheral can raise that channel's request line while the channel's hardware-enable bit is set. Software can write the channel number to the start register. Another channel can finish a block and name this channel as its link target. The engine runs one channel at a time, and the lowest-numbered pending channel goes first. The running channel keeps the engine until its whole block of values has moved.

Each value moves as one read from the source followed by one write to the destination, both on a single memory master port that uses a request and acknowledge handshake. The source and destination addresses each step by the value width, or stay fixed. Each address can also be held inside an aligned window, so that a circular queue wraps back to its start. When a block ends, the engine writes the final addresses back into the descriptor. A second start of the same channel therefore continues from where the first one stopped. The engine then sets the channel's done flag. The interrupt output is the OR of all done flags whose channels have interrupts enabled.

Register map (byte-free word addresses on `reg_addr`). When bit 7 is clear, bits [6:2] select the channel and bits [1:0] select the word: 0 source address, 1 destination address, 2 count (16 bits; 0 behaves as 1), 3 control. Address 0x80 is start: writing it sets the pending bit of the channel named in data bits [4:0]. Address 0x81 reads the done flags, one bit per channel, and writing 1 to a bit clears that flag. Control word bits: [1:0] width (0 = 8 bit, 1 = 16 bit, 2 = 32 bit, 3 acts as 32 bit), [2] source steps, [3] destination steps, [8:4] source window exponent, [13:9] destination window exponent, [14] interrupt enable, [15] hardware-request enable, [16] link enable, [21:17] link target channel.

Top module: `dma_engine`

## Requirements
- R1: After reset all done flags read 0, `irq` is low and `mem_req` is low.
- R2: Width code 0, 1 or 2 moves 1, 2 or 4 bytes per value. `mem_size` carries that code, and the data written is the data read, masked to that width (little-endian, right-justified on the data buses). Destination bytes beyond the width are not touched.
- R3: A block with count N performs exactly N read/write pairs. A count of 1 moves a single value. Each read acknowledge is followed in the next cycle by the matching write request.
- R4: An address whose step bit is set advances by the width in bytes after each value. An address whose step bit is clear stays fixed.
- R5: Writing a channel number to start (0x80) runs that channel.
- R6: A pulse on `hw_req[i]` runs channel i only when its hardware-enable bit is set. When that bit is clear, the pulse has no effect.
- R7: With link enable set, the completion of a channel makes its link target pending, and the target then runs.
- R8: A nonzero window exponent m keeps address bits above m-1 fixed, so the address wraps inside an aligned window of 2^m bytes.
- R9: When several channels are pending together, the lowest-numbered channel runs first.
- R10: A done flag is set only when its channel's block completes, and writing 1 to that bit of 0x81 clears it.
- R11: `irq` is high exactly when some done flag is set whose channel has interrupt enable set.
- R12: After a block completes, the source and destination descriptor words read back the final stepped (and wrapped) addresses.
- R13: `mem_req`, `mem_we` and `mem_addr` hold steady from the raising of a request until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| hw_req | input | 32 | Peripheral request line per channel |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | 32 | Byte address of the access |
| mem_size | output | 2 | Access width code (0, 1, 2) |
| mem_wdata | output | 32 | Write data, right-justified |
| mem_rdata | input | 32 | Read data, right-justified, valid with `mem_ack` |
| mem_ack | input | 1 | Access completes in this cycle |
| irq | output | 1 | Completion interrupt |

## Verification
Each kind of internal fault shows up at the ports in its own way. A corrupted working address or a wrong step shows up on the first access after the fault, as a wrong `mem_addr`, and it persists into the descriptor words read back at the end of the block. A wrong remaining count shows up as too many or too few destination writes, visible once the done flag rises. A pending or priority fault shows up as a wrong order of source reads, or as a done flag that never rises or rises without cause. The bench therefore checks the memory image, the order of accesses and the read-back descriptors right after each completion.

// File: rtl/dma_engine.sv
module dma_engine #(
  parameter int NCH = 32,
  parameter int AW  = 32,
  parameter int CW  = 16
)(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    reg_we,
  input  logic [$clog2(NCH)+2:0]  reg_addr,
  input  logic [31:0]             reg_wdata,
  output logic [31:0]             reg_rdata,
  input  logic [NCH-1:0]          hw_req,
  output logic                    mem_req,
  output logic                    mem_we,
  output logic [AW-1:0]           mem_addr,
  output logic [1:0]              mem_size,
  output logic [31:0]             mem_wdata,
  input  logic [31:0]             mem_rdata,
  input  logic                    mem_ack,
  output logic                    irq
);
  localparam int CHW = $clog2(NCH);
  localparam int CTW = 17 + CHW;
  localparam logic [NCH-1:0] ONE = 1;

  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_RD = 2'd1, ST_WR = 2'd2, ST_FIN = 2'd3} st_t;

  logic [AW-1:0]  src_q [NCH];
  logic [AW-1:0]  dst_q [NCH];
  logic [CW-1:0]  cnt_q [NCH];
  logic [CTW-1:0] ctl_q [NCH];

  logic [NCH-1:0] pend_q, done_q, hwen, inten;
  st_t            st;
  logic [CHW-1:0] cur, sel;
  logic [AW-1:0]  c_src, c_dst;
  logic [CW-1:0]  c_left;
  logic [31:0]    hold;

  logic           glob;
  logic [CHW-1:0] ach;
  logic [CTW-1:0] cctl;
  logic [1:0]     csz;
  logic [31:0]    dmask;
  logic           grant, fin;
  logic [NCH-1:0] sw_set, link_set, dclr, pend_d, done_d;

  assign glob = reg_addr[CHW+2];
  assign ach  = reg_addr[2 +: CHW];
  assign cctl = ctl_q[cur];
  assign csz  = (cctl[1:0] == 2'd3) ? 2'd2 : cctl[1:0];
  assign dmask = (csz == 2'd0) ? 32'h0000_00FF :
                 (csz == 2'd1) ? 32'h0000_FFFF : 32'hFFFF_FFFF;

  always_comb begin
    sel = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (pend_q[i]) sel = CHW'(i);
  end

  always_comb
    for (int i = 0; i < NCH; i++) begin
      hwen[i]  = ctl_q[i][15];
      inten[i] = ctl_q[i][14];
    end

  function automatic logic [AW-1:0] step(input logic [AW-1:0] a, input logic [1:0] sz,
                                          input logic inc, input logic [4:0] m);
    logic [AW-1:0] nx, wm;
    nx = a + (inc ? (AW'(1) << sz) : '0);
    wm = (AW'(1) << m) - AW'(1);
    return (m == 5'd0) ? nx : ((a & ~wm) | (nx & wm));
  endfunction

  assign grant    = (st == ST_IDLE) && (|pend_q);
  assign fin      = (st == ST_FIN);
  assign sw_set   = (reg_we && glob && reg_addr[1:0] == 2'd0) ? (ONE << reg_wdata[CHW-1:0]) : '0;
  assign link_set = (fin && cctl[16]) ? (ONE << cctl[17 +: CHW]) : '0;
  assign dclr     = (reg_we && glob && reg_addr[1:0] == 2'd1) ? reg_wdata[NCH-1:0] : '0;
  assign pend_d   = (pend_q & ~(grant ? (ONE << sel) : '0)) | (hw_req & hwen) | sw_set | link_set;
  assign done_d   = (done_q & ~dclr) | (fin ? (ONE << cur) : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        src_q[i] <= '0;
        dst_q[i] <= '0;
        cnt_q[i] <= '0;
        ctl_q[i] <= '0;
      end
      pend_q <= '0;
      done_q <= '0;
      st     <= ST_IDLE;
      cur    <= '0;
      c_src  <= '0;
      c_dst  <= '0;
      c_left <= '0;
      hold   <= '0;
    end else begin
      pend_q <= pend_d;
      done_q <= done_d;
      if (reg_we && !glob)
        case (reg_addr[1:0])
          2'd0: src_q[ach] <= reg_wdata[AW-1:0];
          2'd1: dst_q[ach] <= reg_wdata[AW-1:0];
          2'd2: cnt_q[ach] <= reg_wdata[CW-1:0];
          default: ctl_q[ach] <= reg_wdata[CTW-1:0];
        endcase
      case (st)
        ST_IDLE:
          if (grant) begin
            cur    <= sel;
            c_src  <= src_q[sel];
            c_dst  <= dst_q[sel];
            c_left <= (cnt_q[sel] == '0) ? CW'(1) : cnt_q[sel];
            st     <= ST_RD;
          end
        ST_RD:
          if (mem_ack) begin
            hold <= mem_rdata & dmask;
            st   <= ST_WR;
          end
        ST_WR:
          if (mem_ack) begin
            c_src  <= step(c_src, csz, cctl[2], cctl[8:4]);
            c_dst  <= step(c_dst, csz, cctl[3], cctl[13:9]);
            c_left <= c_left - CW'(1);
            st     <= (c_left == CW'(1)) ? ST_FIN : ST_RD;
          end
        default: begin
          src_q[cur] <= c_src;
          dst_q[cur] <= c_dst;
          st         <= ST_IDLE;
        end
      endcase
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (glob) begin
      if (reg_addr[1:0] == 2'd1) reg_rdata = 32'(done_q);
    end else
      case (reg_addr[1:0])
        2'd0: reg_rdata = 32'(src_q[ach]);
        2'd1: reg_rdata = 32'(dst_q[ach]);
        2'd2: reg_rdata = 32'(cnt_q[ach]);
        default: reg_rdata = 32'(ctl_q[ach]);
      endcase
  end

  assign mem_req   = (st == ST_RD) || (st == ST_WR);
  assign mem_we    = (st == ST_WR);
  assign mem_addr  = (st == ST_WR) ? c_dst : c_src;
  assign mem_size  = csz;
  assign mem_wdata = hold;
  assign irq       = |(done_q & inten);
endmodule

module dma_engine_chk #(
  parameter int NCH = 32,
  parameter int AW  = 32
)(
  input logic           clk,
  input logic           rst_n,
  input logic           mem_req,
  input logic           mem_we,
  input logic [AW-1:0]  mem_addr,
  input logic [1:0]     mem_size,
  input logic           mem_ack,
  input logic           irq,
  input logic [NCH-1:0] done_q,
  input logic [1:0]     st
);
  // R13
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));
  // R2
  size_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_size != 2'd3);
  // R3
  rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack && !mem_we |=> mem_req && mem_we);
  // R11
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> done_q != '0);
  // R10
  done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q & ~$past(done_q)) != '0 |-> $past(st) == 2'd3);
endmodule

bind dma_engine dma_engine_chk #(.NCH(NCH), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_size(mem_size), .mem_ack(mem_ack), .irq(irq), .done_q(done_q), .st(st));

// File: tb/dma_engine_tb_top.sv
module dma_engine_tb_top;
  localparam int CLK_P = 10;
  localparam logic [7:0] A_START = 8'h80, A_DONE = 8'h81;

  logic clk = 0, rst_n = 0;
  logic reg_we = 0;
  logic [7:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic [31:0] hw_req = 0;
  logic mem_req, mem_we, mem_ack = 0, irq;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = 0;
  logic [1:0] mem_size;

  int tests = 0, fails = 0;
  logic [7:0] mem [0:4095];
  int wr_n = 0, rd_n = 0;
  logic [31:0] rd_log [0:7];

  always #(CLK_P/2) clk = ~clk;

  dma_engine dut_i (.clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hw_req(hw_req), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack), .irq(irq));

  function automatic logic [7:0] pat(input int a);
    return 8'(a * 7 + 3);
  endfunction
  function automatic logic [31:0] patw(input int a);
    return {pat(a+3), pat(a+2), pat(a+1), pat(a)};
  endfunction
  function automatic logic [31:0] memw(input int a);
    return {mem[a+3], mem[a+2], mem[a+1], mem[a]};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) mem_ack <= 0;
    else if (mem_req && !mem_ack) begin
      mem_ack <= 1;
      if (mem_we) begin
        for (int b = 0; b < (1 << mem_size); b++)
          mem[(mem_addr + b) & 32'hFFF] = mem_wdata[8*b +: 8];
        wr_n = wr_n + 1;
      end else begin
        mem_rdata <= memw(mem_addr & 32'hFFF);
        if (rd_n < 8) rd_log[rd_n] = mem_addr;
        rd_n = rd_n + 1;
      end
    end else mem_ack <= 0;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask
  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask
  function automatic logic [31:0] ctl(input int sz, si, di, sm, dm, ie, he, le, lc);
    return 32'(sz) | 32'(si) << 2 | 32'(di) << 3 | 32'(sm) << 4 | 32'(dm) << 9 |
           32'(ie) << 14 | 32'(he) << 15 | 32'(le) << 16 | 32'(lc) << 17;
  endfunction
  task automatic setup(input int ch, input logic [31:0] s, d, n, c);
    wr(8'(ch*4), s); wr(8'(ch*4+1), d); wr(8'(ch*4+2), n); wr(8'(ch*4+3), c);
  endtask
  task automatic wait_done(input logic [31:0] m);
    logic [31:0] v;
    for (int i = 0; i < 2000; i++) begin
      rd(A_DONE, v);
      if ((v & m) == m) break;
    end
  endtask
  task automatic pulse(input logic [31:0] m);
    @(negedge clk); hw_req = m; @(negedge clk); hw_req = 0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(A_DONE, v);
    chk("R1 done", v, 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 mem_req", 32'(mem_req), 0);
  endtask

  task automatic t_word_block;
    logic [31:0] v;
    wr_n = 0;
    setup(0, 32'h000, 32'h400, 4, ctl(2, 1, 1, 0, 0, 1, 0, 0, 0));
    wr(A_START, 0);
    wait_done(1);
    for (int k = 0; k < 4; k++) chk("R5 R4 word copy", memw(32'h400 + 4*k), patw(4*k));
    chk("R3 four writes", 32'(wr_n), 4);
    chk("R11 irq set", 32'(irq), 1);
    rd(8'd0, v); chk("R12 src final", v, 32'h010);
    rd(8'd1, v); chk("R12 dst final", v, 32'h410);
    wr(A_DONE, 32'h1);
    rd(A_DONE, v); chk("R10 w1c", v, 0);
    chk("R11 irq clear", 32'(irq), 0);
  endtask

  task automatic t_byte_fixed;
    logic [31:0] v;
    wr_n = 0;
    setup(1, 32'h020, 32'h480, 3, ctl(0, 1, 0, 0, 0, 0, 0, 0, 0));
    wr(A_START, 1);
    wait_done(2);
    chk("R4 fixed dst last byte", 32'(mem[12'h480]), 32'(pat(32'h22)));
    chk("R2 neighbour byte", 32'(mem[12'h481]), 32'(pat(32'h481)));
    chk("R3 three writes", 32'(wr_n), 3);
    rd(8'd5, v); chk("R4 dst unchanged", v, 32'h480);
    rd(8'd4, v); chk("R12 src byte step", v, 32'h023);
    wr(A_DONE, 32'hFFFF_FFFF);
  endtask

  task automatic t_half_single;
    logic [31:0] v;
    wr_n = 0;
    setup(2, 32'h030, 32'h4A0, 1, ctl(1, 1, 1, 0, 0, 0, 0, 0, 0));
    wr(A_START, 2);
    wait_done(4);
    chk("R2 half lo", 32'(mem[12'h4A0]), 32'(pat(32'h30)));
    chk("R2 half hi", 32'(mem[12'h4A1]), 32'(pat(32'h31)));
    chk("R2 untouched", 32'(mem[12'h4A2]), 32'(pat(32'h4A2)));
    chk("R3 single", 32'(wr_n), 1);
    rd(8'd8, v); chk("R4 half step", v, 32'h032);
    wr(A_DONE, 32'hFFFF_FFFF);
  endtask

  task automatic t_hw_request;
    logic [31:0] v;
    setup(7, 32'h040, 32'h4C0, 1, ctl(2, 1, 1, 0, 0, 0, 0, 0, 0));
    pulse(32'h80);
    repeat (40) @(negedge clk);
    rd(A_DONE, v); chk("R6 ignored done", v & 32'h80, 0);
    chk("R6 ignored mem", memw(32'h4C0), patw(32'h4C0));
    wr(8'd31, ctl(2, 1, 1, 0, 0, 0, 1, 0, 0));
    pulse(32'h80);
    wait_done(32'h80);
    chk("R6 enabled copy", memw(32'h4C0), patw(32'h40));
    wr(A_DONE, 32'hFFFF_FFFF);
  endtask

  task automatic t_link;
    logic [31:0] v;
    setup(3, 32'h050, 32'h4D0, 1, ctl(2, 1, 1, 0, 0, 0, 0, 1, 4));
    setup(4, 32'h054, 32'h4D4, 1, ctl(2, 1, 1, 0, 0, 0, 0, 0, 0));
    wr(A_START, 3);
    wait_done(32'h18);
    rd(A_DONE, v); chk("R7 both done", v, 32'h18);
    chk("R7 linked copy", memw(32'h4D4), patw(32'h54));
    chk("R11 no enable no irq", 32'(irq), 0);
    wr(A_DONE, 32'hFFFF_FFFF);
  endtask

  task automatic t_modulo;
    logic [31:0] v;
    setup(5, 32'h104, 32'h500, 4, ctl(2, 1, 1, 3, 0, 0, 0, 0, 0));
    wr(A_START, 5);
    wait_done(32'h20);
    chk("R8 wrap 0", memw(32'h500), patw(32'h104));
    chk("R8 wrap 1", memw(32'h504), patw(32'h100));
    chk("R8 wrap 2", memw(32'h508), patw(32'h104));
    chk("R8 wrap 3", memw(32'h50C), patw(32'h100));
    rd(8'd20, v); chk("R12 wrapped src", v, 32'h104);
    wr(A_DONE, 32'hFFFF_FFFF);
  endtask

  task automatic t_priority;
    setup(9, 32'h070, 32'h600, 1, ctl(2, 1, 1, 0, 0, 0, 1, 0, 0));
    setup(6, 32'h060, 32'h600, 1, ctl(2, 1, 1, 0, 0, 0, 1, 0, 0));
    rd_n = 0;
    pulse(32'h240);
    wait_done(32'h240);
    chk("R9 first read", rd_log[0], 32'h060);
    chk("R9 second read", rd_log[1], 32'h070);
    chk("R9 last writer", memw(32'h600), patw(32'h70));
    wr(A_DONE, 32'hFFFF_FFFF);
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = pat(i);
    repeat (3) @(negedge clk);
    rst_n = 1;
    fork
      begin
        t_reset; t_word_block; t_byte_fixed; t_half_single;
        t_hw_request; t_link; t_modulo; t_priority;
      end
      begin
        repeat (100000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule